// File: doc/BRIEF.md
# Text Cursor Blink Generator

This block marks the character cell that holds the text cursor in a character-cell display controller. The timing generator supplies an end-of-line strobe together with the scanline-within-row before and after that line boundary. From these the block keeps a single flag that says whether the scanlines now being drawn fall inside the cursor band. The band is delimited by a first and a last scanline, both programmable. The flag is stateful: a first-scanline match sets it, and it stays set until the last scanline has been drawn.

On every character clock the block compares the fetch address of the character being produced with the programmed cursor address. The cursor output is raised for that cell only when three conditions hold: the band flag is set, the addresses match, and the selected blink pattern allows display in the current field. There are four blink patterns, selected by a 2-bit mode: symmetric blink, forced off, steady, and short-on/long-off. Each pattern is derived from the low four bits of the frame's field counter.

Top module: `cursor_blink_gen`

## Requirements
- R1: Synchronous active-high reset clears the band flag and the cursor output, so `cursor_out` is 0 at the first probe after reset even with matching addresses and steady mode.
- R2: On a cycle with `eol` high, the band flag sets when `row_next` equals `band_first`.
- R3: On a cycle with `eol` high, the band flag clears when `row_now` equals `band_last`, unless `row_next` also equals `band_first`, in which case it stays set.
- R4: When `eol` is low, the band flag keeps its value.
- R5: `cursor_out` is a register. It is 1 in the cycle after a clock edge at which the band flag was set, `fetch_addr` equalled `cursor_addr` (14 bits) and the blink pattern allowed display. Otherwise it is 0.
- R6: Blink mode 2'b01 keeps `cursor_out` at 0.
- R7: Blink mode 2'b10 shows the cursor in every field, whatever the field count.
- R8: Blink mode 2'b00 shows the cursor only when `field_cnt[3]` is 1, giving 8 fields on and 8 fields off.
- R9: Blink mode 2'b11 shows the cursor only when `field_cnt[3:2]` is 2'b11, giving 4 fields on out of 16.
- R10: With `band_first` equal to `band_last`, the band covers exactly one scanline: it sets when that row begins and clears at the following end-of-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| eol | input | 1 | End-of-line strobe, one cycle |
| row_now | input | 5 | Scanline within row before the line boundary |
| row_next | input | 5 | Scanline within row after the line boundary |
| field_cnt | input | 4 | Low four bits of the field counter |
| band_first | input | 5 | First scanline of the cursor band |
| band_last | input | 5 | Last scanline of the cursor band |
| blink_mode | input | 2 | 00 symmetric, 01 off, 10 steady, 11 short-on |
| fetch_addr | input | 14 | Address of the character being produced |
| cursor_addr | input | 14 | Cursor character address |
| cursor_out | output | 1 | Cursor marker for the character, registered |

## Verification
A band flag that is stuck set or stuck clear shows at the port right away. The next probe with matching addresses in steady mode returns the wrong value one clock after the probe is driven. A flag that updates at the wrong time, or that ignores the set-over-clear ordering, can only be observed after the following end-of-line strobe. The bench therefore probes after every strobe and also on idle cycles. A blink decode error on a field-count bit appears only for field values that isolate that bit, so each mode is driven with counts that separate bit 3 from bit 2.

// File: rtl/cursor_blink_pkg.sv
package cursor_blink_pkg;

    localparam int ROW_W = 5;

    typedef enum logic [1:0] {
        BLINK_SYM    = 2'b00,
        BLINK_OFF    = 2'b01,
        BLINK_STEADY = 2'b10,
        BLINK_SHORT  = 2'b11
    } blink_e;

    typedef struct packed {
        logic             strobe;
        logic [ROW_W-1:0] old_row;
        logic [ROW_W-1:0] new_row;
    } line_evt_t;

    // display permission for a field, per blink pattern
    function automatic logic blink_allows(blink_e mode, logic [3:0] field);
        logic ok;
        case (mode)
            BLINK_SYM:    ok = field[3];
            BLINK_OFF:    ok = 1'b0;
            BLINK_STEADY: ok = 1'b1;
            BLINK_SHORT:  ok = field[3] & field[2];
            default:      ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cursor_band_track.sv
module cursor_band_track
    import cursor_blink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  line_evt_t        evt,
    input  logic [ROW_W-1:0] first_row,
    input  logic [ROW_W-1:0] last_row,
    output logic             in_band
);
    logic band_q;
    logic band_d;

    always_comb begin
        band_d = band_q;
        if (evt.strobe) begin
            // leaving the last row first, then entering the first row
            if (evt.old_row == last_row)
                band_d = 1'b0;
            if (evt.new_row == first_row)
                band_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) band_q <= 1'b0;
        else     band_q <= band_d;
    end

    assign in_band = band_q;
endmodule

// File: rtl/cursor_blink_gate.sv
module cursor_blink_gate
    import cursor_blink_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [3:0] field,
    output logic       show
);
    blink_e mode_e;
    assign mode_e = blink_e'(mode);
    assign show   = blink_allows(mode_e, field);
endmodule

// File: rtl/cursor_addr_mark.sv
module cursor_addr_mark #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] target,
    output logic              mark
);
    logic mark_q;

    always_ff @(posedge clk) begin
        if (rst) mark_q <= 1'b0;
        else     mark_q <= enable && (addr == target);
    end

    assign mark = mark_q;
endmodule

// File: rtl/cursor_blink_gen.sv
module cursor_blink_gen
    import cursor_blink_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eol,
    input  logic [ROW_W-1:0]  row_now,
    input  logic [ROW_W-1:0]  row_next,
    input  logic [3:0]        field_cnt,
    input  logic [ROW_W-1:0]  band_first,
    input  logic [ROW_W-1:0]  band_last,
    input  logic [1:0]        blink_mode,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] cursor_addr,
    output logic              cursor_out
);
    line_evt_t evt;
    logic      band_on;
    logic      blink_ok;

    assign evt.strobe  = eol;
    assign evt.old_row = row_now;
    assign evt.new_row = row_next;

    cursor_band_track u_band (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .first_row (band_first),
        .last_row  (band_last),
        .in_band   (band_on)
    );

    cursor_blink_gate u_gate (
        .mode  (blink_mode),
        .field (field_cnt),
        .show  (blink_ok)
    );

    cursor_addr_mark #(.ADDR_W(ADDR_W)) u_mark (
        .clk    (clk),
        .rst    (rst),
        .enable (band_on & blink_ok),
        .addr   (fetch_addr),
        .target (cursor_addr),
        .mark   (cursor_out)
    );
endmodule

// File: rtl/cursor_blink_chk.sv
module cursor_blink_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              eol,
    input logic [4:0]        row_now,
    input logic [4:0]        row_next,
    input logic [3:0]        field_cnt,
    input logic [4:0]        band_first,
    input logic [4:0]        band_last,
    input logic [1:0]        blink_mode,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] cursor_addr,
    input logic              band_on,
    input logic              cursor_out
);
    p_band_set_r2: assert property (@(posedge clk) disable iff (rst)
        (eol && row_next == band_first) |=> band_on);

    p_band_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (eol && row_now == band_last && row_next != band_first) |=> !band_on);

    p_band_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !eol |=> $stable(band_on));

    p_addr_match_r5: assert property (@(posedge clk) disable iff (rst)
        cursor_out |-> $past(fetch_addr == cursor_addr));

    p_mode_off_r6: assert property (@(posedge clk) disable iff (rst)
        cursor_out |-> ($past(blink_mode) != 2'b01));

    p_sym_blink_r8: assert property (@(posedge clk) disable iff (rst)
        (cursor_out && $past(blink_mode) == 2'b00) |-> $past(field_cnt[3]));

    p_short_blink_r9: assert property (@(posedge clk) disable iff (rst)
        (cursor_out && $past(blink_mode) == 2'b11) |-> ($past(field_cnt[3:2]) == 2'b11));
endmodule

bind cursor_blink_gen cursor_blink_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eol         (eol),
    .row_now     (row_now),
    .row_next    (row_next),
    .field_cnt   (field_cnt),
    .band_first  (band_first),
    .band_last   (band_last),
    .blink_mode  (blink_mode),
    .fetch_addr  (fetch_addr),
    .cursor_addr (cursor_addr),
    .band_on     (band_on),
    .cursor_out  (cursor_out)
);

// File: tb/cursor_blink_gen_bench.sv
module cursor_blink_gen_bench;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              eol = 1'b0;
    logic [4:0]        row_now = '0;
    logic [4:0]        row_next = '0;
    logic [3:0]        field_cnt = '0;
    logic [4:0]        band_first = 5'd3;
    logic [4:0]        band_last = 5'd5;
    logic [1:0]        blink_mode = 2'b10;
    logic [ADDR_W-1:0] fetch_addr = 14'h0000;
    logic [ADDR_W-1:0] cursor_addr = 14'h2A5C;
    logic              cursor_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cursor_blink_gen #(.ADDR_W(ADDR_W)) u_cursor_blink_gen (
        .clk(clk), .rst(rst), .eol(eol), .row_now(row_now), .row_next(row_next),
        .field_cnt(field_cnt), .band_first(band_first), .band_last(band_last),
        .blink_mode(blink_mode), .fetch_addr(fetch_addr), .cursor_addr(cursor_addr),
        .cursor_out(cursor_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: cursor_out=%0b expected %0b", req, act, exp);
        end
    endtask

    // one end-of-line strobe, driven and released on negative edges
    task automatic line_end(input logic [4:0] r_old, input logic [4:0] r_new);
        @(negedge clk);
        eol = 1'b1; row_now = r_old; row_next = r_new;
        @(negedge clk);
        eol = 1'b0;
    endtask

    // drive a matching address for one edge and sample the registered result
    task automatic probe(input logic exp, input string req);
        fetch_addr = cursor_addr;
        @(posedge clk);
        @(negedge clk);
        check(cursor_out, exp, req);
        fetch_addr = cursor_addr ^ 14'h0001;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b0;
        probe(1'b0, "R1");
    endtask

    task automatic t_band;
        band_first = 5'd3; band_last = 5'd5; blink_mode = 2'b10;
        line_end(5'd1, 5'd2); probe(1'b0, "R2");
        line_end(5'd2, 5'd3); probe(1'b1, "R2");
        repeat (3) @(negedge clk);
        probe(1'b1, "R4");
        line_end(5'd3, 5'd4); probe(1'b1, "R4");
        line_end(5'd4, 5'd5); probe(1'b1, "R3");
        line_end(5'd5, 5'd6); probe(1'b0, "R3");
        repeat (2) @(negedge clk);
        probe(1'b0, "R4");
    endtask

    task automatic t_addr;
        line_end(5'd2, 5'd3);
        fetch_addr = cursor_addr ^ 14'h2000;
        @(posedge clk); @(negedge clk);
        check(cursor_out, 1'b0, "R5");
        fetch_addr = cursor_addr;
        @(posedge clk); @(negedge clk);
        check(cursor_out, 1'b1, "R5");
        fetch_addr = cursor_addr ^ 14'h0001;
        @(posedge clk); @(negedge clk);
        check(cursor_out, 1'b0, "R5");
    endtask

    task automatic t_modes;
        blink_mode = 2'b01; field_cnt = 4'd12; probe(1'b0, "R6");
        field_cnt = 4'd8;  probe(1'b0, "R6");
        blink_mode = 2'b10; field_cnt = 4'd0; probe(1'b1, "R7");
        field_cnt = 4'd5;  probe(1'b1, "R7");
        blink_mode = 2'b00; field_cnt = 4'd8; probe(1'b1, "R8");
        field_cnt = 4'd7;  probe(1'b0, "R8");
        field_cnt = 4'd15; probe(1'b1, "R8");
        blink_mode = 2'b11; field_cnt = 4'd12; probe(1'b1, "R9");
        field_cnt = 4'd8;  probe(1'b0, "R9");
        field_cnt = 4'd4;  probe(1'b0, "R9");
        field_cnt = 4'd14; probe(1'b1, "R9");
        blink_mode = 2'b10; field_cnt = 4'd0;
    endtask

    task automatic t_single;
        line_end(5'd5, 5'd0);
        band_first = 5'd7; band_last = 5'd7;
        line_end(5'd5, 5'd6); probe(1'b0, "R10");
        line_end(5'd6, 5'd7); probe(1'b1, "R10");
        line_end(5'd7, 5'd0); probe(1'b0, "R10");
    endtask

    task automatic t_set_wins;
        band_first = 5'd2; band_last = 5'd2;
        line_end(5'd1, 5'd2); probe(1'b1, "R3");
        line_end(5'd2, 5'd2); probe(1'b1, "R3");
        line_end(5'd2, 5'd3); probe(1'b0, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_band();
        t_addr();
        t_modes();
        t_single();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++;
                    failures++;
                    $display("FAIL watchdog: run did not complete");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule